// File: doc/BRIEF.md
# Chip-Select Refreshed Watchdog

This block supervises a host by watching its chip-select line. Every change of chip select, whether it goes high or low, restarts an internal cycle counter. If the host stays silent for a whole timeout window, the block emits a one-cycle timeout pulse. A neighbouring reset generator turns that pulse into a system reset. The window length is a parameter in clock cycles. The default of 52429 cycles gives about 1.6 s at a 32.768 kHz clock.

The counter is frozen at zero for as long as any hold source is present. One source is a synchronous power-up hold input, which the reset generator drives high while the supply is below its threshold and during the following stretch period. The other two are external reset requests: one active high and one active low. When several sources overlap, counting resumes only after the last of them has cleared. Chip select and both external requests are asynchronous, so each passes through a synchroniser of SYNC_STAGES flops before it is used. A registered edge detector then turns a chip-select change into a one-cycle kick. Once a timeout's reset stretch ends, the counter starts again from zero, so a host that stays silent receives a timeout once per window.

Top module: `cs_watchdog`

## Requirements
- R1: While rst_ni is low, timeout_o is 0. After rst_ni rises, the count starts from zero: with no hold source and chip select steady at 0, the first pulse comes after exactly TIMEOUT_CYCLES rising edges.
- R2: With no hold source and no chip-select change, timeout_o goes high after the TIMEOUT_CYCLES-th rising edge following the end of the hold. It repeats every TIMEOUT_CYCLES edges after that.
- R3: Each timeout pulse lasts exactly one clock cycle.
- R4: While pwr_hold_i is 1, the count stays at zero and no pulse is produced. When pwr_hold_i falls, counting begins at the next edge, so the first pulse follows TIMEOUT_CYCLES edges after the release.
- R5: A rising or a falling change of cs_i clears the count at the (SYNC_STAGES+1)-th edge after the change. The next pulse therefore follows TIMEOUT_CYCLES+SYNC_STAGES+1 edges after the change.
- R6: While ext_rst_req_i is 1, the watchdog is frozen and produces no pulse. After it returns to 0, with no other hold source, the first pulse follows TIMEOUT_CYCLES+SYNC_STAGES edges.
- R7: While ext_rst_req_ni is 0, the watchdog is frozen and produces no pulse. After it returns to 1, with no other hold source, the first pulse follows TIMEOUT_CYCLES+SYNC_STAGES edges.
- R8: When hold sources overlap, counting resumes only after the last one has cleared. No pulse is produced in the cycle after any hold source is seen.
- R9: Changes of chip select spaced closer together than TIMEOUT_CYCLES edges prevent every timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Watchdog clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cs_i | input | 1 | Host chip select (asynchronous); any change is a kick |
| pwr_hold_i | input | 1 | Synchronous hold: supply not yet good, or power-up stretch still running |
| ext_rst_req_i | input | 1 | External reset request, active high (asynchronous) |
| ext_rst_req_ni | input | 1 | External reset request, active low (asynchronous) |
| timeout_o | output | 1 | One-cycle pulse at watchdog expiry |

## Verification
The assertions assume that pwr_hold_i is already synchronous to clk_i, and that TIMEOUT_CYCLES is at least 2, so that a pulse can never be followed by another pulse in the next cycle. They also assume the asynchronous inputs settle well within one clock period. The stimulus respects these assumptions by changing every input only at the falling clock edge. It also holds each external request for many cycles, so each request passes cleanly through the synchroniser.

// File: rtl/csw_pkg.sv
package csw_pkg;
  localparam int unsigned CSW_DEF_TIMEOUT = 52429;
  localparam int unsigned CSW_DEF_SYNC    = 2;

  typedef struct packed {
    logic cs;
    logic req_hi;
    logic req_lo_n;
  } csw_async_t;

  localparam csw_async_t CSW_ASYNC_IDLE = '{cs: 1'b0, req_hi: 1'b0, req_lo_n: 1'b1};
endpackage

// File: rtl/csw_sync.sv
module csw_sync #(
  parameter int unsigned    WIDTH   = 3,
  parameter int unsigned    STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_comb stage_d[g] = d_i;
    end else begin : g_rest
      always_comb stage_d[g] = stage_q[g-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= RST_VAL;
      else         stage_q[g] <= stage_d[g];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/csw_kick.sv
module csw_kick #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic kick_o
);
  logic last_q;
  logic last_d;

  always_comb last_d = lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= RST_VAL;
    else         last_q <= last_d;
  end

  assign kick_o = lvl_i ^ last_q;
endmodule

// File: rtl/csw_count.sv
module csw_count #(
  parameter int unsigned TIMEOUT_CYCLES = 52429
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic freeze_i,
  input  logic kick_i,
  output logic tmo_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYCLES);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tmo_q, tmo_d;
  logic             count_en;
  logic             at_last;

  always_comb begin
    count_en = ~freeze_i & ~kick_i;
    at_last  = (cnt_q == LAST_C);
    cnt_d    = cnt_q;
    tmo_d    = 1'b0;
    if (!count_en) begin
      cnt_d = '0;
    end else if (at_last) begin
      cnt_d = '0;
      tmo_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tmo_q <= tmo_d;
    end
  end

  assign tmo_o = tmo_q;

  AST_FREEZE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> (cnt_q == '0)); // R4
  AST_KICK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (cnt_q == '0)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_C); // R2
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!freeze_i && !kick_i && cnt_q != LAST_C) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R2
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_q |=> !tmo_q); // R3
  AST_NO_TMO_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> !tmo_q); // R8
endmodule

// File: rtl/cs_watchdog.sv
module cs_watchdog
  import csw_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = CSW_DEF_TIMEOUT,
  parameter int unsigned SYNC_STAGES    = CSW_DEF_SYNC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic pwr_hold_i,
  input  logic ext_rst_req_i,
  input  logic ext_rst_req_ni,
  output logic timeout_o
);
  localparam int unsigned ASYNC_W = $bits(csw_async_t);

  csw_async_t raw_in;
  csw_async_t sync_in;
  logic       kick;
  logic       freeze;

  assign raw_in = '{cs: cs_i, req_hi: ext_rst_req_i, req_lo_n: ext_rst_req_ni};

  csw_sync #(
    .WIDTH   (ASYNC_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (CSW_ASYNC_IDLE)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_in),
    .q_o    (sync_in)
  );

  csw_kick #(
    .RST_VAL (CSW_ASYNC_IDLE.cs)
  ) u_kick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (sync_in.cs),
    .kick_o (kick)
  );

  assign freeze = pwr_hold_i | sync_in.req_hi | ~sync_in.req_lo_n;

  csw_count #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .freeze_i (freeze),
    .kick_i   (kick),
    .tmo_o    (timeout_o)
  );
endmodule

// File: tb/sim_cs_watchdog.sv
module sim_cs_watchdog;
  localparam int T  = 20;
  localparam int SS = 2;
  localparam int NV = 8;
  // fields: hold, req_hi, req_lo_n, cs, cycles[15:0], expected pulses[7:0]
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b1, 1'b0, 16'd50, 8'd0},  // R4 held
    {1'b0, 1'b0, 1'b1, 1'b0, 16'd45, 8'd2},  // R2 repeat
    {1'b0, 1'b0, 1'b1, 1'b1, 16'd30, 8'd1},  // R5 rising kick
    {1'b0, 1'b1, 1'b1, 1'b1, 16'd40, 8'd0},  // R6 frozen
    {1'b0, 1'b0, 1'b0, 1'b1, 16'd40, 8'd0},  // R7 frozen
    {1'b1, 1'b0, 1'b1, 1'b1, 16'd30, 8'd0},  // R8 handover
    {1'b0, 1'b0, 1'b1, 1'b1, 16'd25, 8'd1},  // R4 release
    {1'b0, 1'b0, 1'b1, 1'b0, 16'd30, 8'd1}   // R5 falling kick
  };

  logic clk = 1'b0;
  logic rst_n, cs, hold, rq_hi, rq_lo_n;
  logic tmo;
  int   checks = 0;
  int   fails  = 0;

  always #2 clk = ~clk;

  cs_watchdog #(.TIMEOUT_CYCLES(T), .SYNC_STAGES(SS)) u0 (
    .clk_i (clk), .rst_ni (rst_n), .cs_i (cs), .pwr_hold_i (hold),
    .ext_rst_req_i (rq_hi), .ext_rst_req_ni (rq_lo_n), .timeout_o (tmo)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_pulses(input int n, output int p);
    p = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tmo) p++;
    end
  endtask

  task automatic wait_pulse(input int maxn, output int idx);
    idx = 0;
    for (int i = 1; i <= maxn; i++) begin
      @(negedge clk);
      if (tmo) begin
        idx = i;
        break;
      end
    end
  endtask

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int p, idx, hi_seen;
    rst_n = 1'b0; cs = 1'b0; hold = 1'b0; rq_hi = 1'b0; rq_lo_n = 1'b1;
    // R1: in reset with no hold, the output stays low
    hi_seen = 0;
    for (int i = 0; i < 3 * T; i++) begin
      @(negedge clk);
      if (tmo) hi_seen++;
    end
    check(hi_seen == 0, "R1 reset quiet", hi_seen, 0);
    hold = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      hold    = VEC[v][27];
      rq_hi   = VEC[v][26];
      rq_lo_n = VEC[v][25];
      cs      = VEC[v][24];
      count_pulses(int'(VEC[v][23:8]), p);
      check(p == int'(VEC[v][7:0]), $sformatf("R2/R4-R8 vector %0d", v), p, int'(VEC[v][7:0]));
    end

    // R2/R3: exact pulse position, width and period
    hold = 1'b1; count_pulses(3, p);
    hold = 1'b0;
    wait_pulse(T + 5, idx);
    check(idx == T, "R2 first pulse edge", idx, T);
    @(negedge clk);
    check(tmo == 1'b0, "R3 pulse width", int'(tmo), 0);
    wait_pulse(T + 5, idx);
    check(idx == T - 1, "R2 period", idx + 1, T);

    // R9: periodic chip-select changes keep it quiet
    hold = 1'b1; count_pulses(3, p);
    hold = 1'b0;
    hi_seen = 0;
    for (int k = 0; k < 20; k++) begin
      count_pulses(10, p);
      hi_seen += p;
      cs = ~cs;
    end
    check(hi_seen == 0, "R9 kept alive", hi_seen, 0);

    // R5: falling change exact position
    hold = 1'b1; cs = 1'b1; count_pulses(5, p);
    hold = 1'b0; count_pulses(5, p);
    cs = 1'b0;
    wait_pulse(2 * T, idx);
    check(idx == T + SS + 1, "R5 falling kick position", idx, T + SS + 1);

    // R6: active-high request release latency
    hold = 1'b1; count_pulses(3, p);
    rq_hi = 1'b1; count_pulses(3, p);
    hold = 1'b0; count_pulses(10, p);
    check(p == 0, "R6 frozen by request", p, 0);
    rq_hi = 1'b0;
    wait_pulse(2 * T, idx);
    check(idx == T + SS, "R6 release latency", idx, T + SS);

    // R7: active-low request release latency
    hold = 1'b1; count_pulses(3, p);
    rq_lo_n = 1'b0; count_pulses(3, p);
    hold = 1'b0; count_pulses(2 * T, p);
    check(p == 0, "R7 frozen by request", p, 0);
    rq_lo_n = 1'b1;
    wait_pulse(2 * T, idx);
    check(idx == T + SS, "R7 release latency", idx, T + SS);

    // R8: request released first, power hold last
    hold = 1'b1; rq_lo_n = 1'b0; count_pulses(5, p);
    rq_lo_n = 1'b1; count_pulses(10, p);
    hold = 1'b0;
    wait_pulse(2 * T, idx);
    check(idx == T, "R8 later source governs", idx, T);

    // R1: reset in mid-count clears the count
    count_pulses(T / 2, p);
    rst_n = 1'b0;
    @(negedge clk);
    check(tmo == 1'b0, "R1 output in reset", int'(tmo), 0);
    rst_n = 1'b1;
    wait_pulse(2 * T, idx);
    check(idx == T, "R1 count restarts", idx, T);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule